// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

A synthesizable behavioural model of a small synchronous burst SRAM. The words are 36 bits wide and split into four 9-bit byte lanes. Address, control and write data are registered on the rising clock edge. Read data leaves through a one-stage output register, so a word read at one edge reaches the outputs after the next edge. A real tristate bus is replaced by separate write-data and read-data ports and a drive-enable output.

A cycle starts when one of two address strobes is low. The processor strobe is gated by the chip enable and always starts a read. The controller strobe starts a write when the write controls ask for one, and a read when they do not. When both strobes are high, the cycle continues the current burst. With the advance input low it steps to the next word of a four-word burst, which wraps back to its first word. With the advance input high it repeats the current word. A static order input chooses between a linear and an interleaved walk over the two low address bits. Output enable and an active write on the inputs switch the drivers off without waiting for a clock. A sleep input freezes the whole block and keeps the memory contents.

Top module: `burst_sram`

## Requirements
- R1: The block is chosen only when `cen_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A start cycle (`pstb_n`=0 with `cen_n`=0, or `cstb_n`=0) without that selection ends the burst. `drv_en` is then 0 from the second edge after that cycle onward, and later continue cycles make no access.
- R2: A start with `pstb_n`=0 and `cen_n`=0 reads the word at `addr` whatever the write controls are. Write controls given in the next, continuing cycle do write.
- R3: A start with `cstb_n`=0 and no processor start writes at `addr` if `gwr_n`=0, or if `bwen_n`=0 with at least one `bsel_n` bit low. In every other case it reads at `addr`.
- R4: With both strobes high during a live burst, `adv_n`=0 moves to the next burst word and `adv_n`=1 repeats the current one. The cycle writes or reads according to that cycle's write controls. After four words the burst wraps to its first word.
- R5: The burst offset on `addr[1:0]` is (first + beat) mod 4 when `order_il`=0 and first XOR beat when `order_il`=1. The upper address bits stay fixed.
- R6: `gwr_n`=0 writes all four lanes regardless of `bsel_n`. With `bwen_n`=1, `bsel_n` has no effect and only `gwr_n` can write.
- R7: With `bwen_n`=0 and `gwr_n`=1, each low `bsel_n[i]` writes lane i. Lane i is data bits [8i+7:8i] plus bit 32+i. Several lanes may be written in one cycle.
- R8: A read registered at edge n shows its word on `rdata` after edge n+1. A continuing burst delivers one word per edge.
- R9: Write data is taken at the edge of the write cycle. A read started in the very next cycle at the same address returns it.
- R10: `oen_n`=1 forces `drv_en` to 0 within the same cycle and does not change `rdata`.
- R11: While the inputs request a write outside a processor-start cycle, `drv_en` is 0 within the same cycle.
- R12: While `sleep`=1, no state changes: `rdata` holds, stimulus on the inputs is ignored, the memory is kept, and `drv_en` is 0.
- R13: Synchronous reset clears `rdata` to 0, sets `drv_en` to 0 and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for start cycles |
| cen_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write gate, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oen_n | input | 1 | Output enable, active low, unclocked |
| sleep | input | 1 | Freeze and power-down request, active high |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | 36 | Write data (lane bodies low, lane parity bits high) |
| rdata | output | 36 | Registered read data |
| drv_en | output | 1 | High when read data should be driven |

## Verification
A read registered at edge n is due on `rdata` after edge n+1. The scoreboard therefore stamps each expected word with the cycle count two edges ahead of the cycle that issues it. The monitor compares it mid-cycle in that cycle. `drv_en` is unclocked in its output-enable and write-request terms, so in the same mid-cycle sample it is compared against the inputs held in that cycle. Deselects and writes turn the drivers off only from the second edge after their cycle, and the direct checks wait that long. The sleep checks compare `rdata` against the value taken just before sleep began.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      load;
        logic      drop;
        logic      step;
    } cyc_ctl_t;

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] first,
        input logic [BURST_W-1:0] beat,
        input logic               interleave
    );
        return interleave ? (first ^ beat) : (first + beat);
    endfunction

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cen_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             live,
    output cyc_ctl_t         ctl,
    output logic [LANES-1:0] wmask,
    output logic             pins_write
);

    logic             p_go;
    logic             any_go;
    logic             chosen;
    logic [LANES-1:0] req_mask;

    always_comb begin
        p_go   = !pstb_n && !cen_n;
        any_go = p_go || !cstb_n;
        chosen = !cen_n && sel_hi && !sel_lo_n;

        if (!gwr_n)       req_mask = '1;
        else if (!bwen_n) req_mask = ~bsel_n;
        else              req_mask = '0;

        pins_write = !p_go && (|req_mask);

        ctl.kind = ACC_NONE;
        ctl.load = 1'b0;
        ctl.drop = 1'b0;
        ctl.step = 1'b0;
        wmask    = '0;

        if (any_go) begin
            if (!chosen) begin
                ctl.drop = 1'b1;
            end else begin
                ctl.load = 1'b1;
                if (!p_go && (|req_mask)) begin
                    ctl.kind = ACC_WRITE;
                    wmask    = req_mask;
                end else begin
                    ctl.kind = ACC_READ;
                end
            end
        end else if (live) begin
            ctl.step = !adv_n;
            if (|req_mask) begin
                ctl.kind = ACC_WRITE;
                wmask    = req_mask;
            end else begin
                ctl.kind = ACC_READ;
            end
        end
    end

endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic              drop,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              live,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] beat_now;
    logic               live_q;

    assign beat_now = step ? beat_q + BURST_W'(1) : beat_q;
    assign live     = live_q;

    always_comb begin
        if (load)
            acc_addr = ext_addr;
        else
            acc_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_offset(base_q[BURST_W-1:0], beat_now, ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            live_q <= 1'b0;
        end else if (en) begin
            if (load) begin
                base_q <= ext_addr;
                beat_q <= '0;
                live_q <= 1'b1;
            end else if (drop) begin
                live_q <= 1'b0;
            end else if (step) begin
                beat_q <= beat_now;
            end
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W      = 8,
    parameter int LANES       = 4,
    parameter int LANE_DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                en,
    input  logic                                wr,
    input  logic                                rd,
    input  logic [LANES-1:0]                    wmask,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [LANES*(LANE_DATA_W+1)-1:0]    wdata,
    output logic [LANES*(LANE_DATA_W+1)-1:0]    rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = LANE_DATA_W + 1;
    localparam int BODY_W = LANES * LANE_DATA_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] din;
        logic [LANE_W-1:0] dout_q;

        assign din = {wdata[BODY_W+i], wdata[i*LANE_DATA_W +: LANE_DATA_W]};

        always_ff @(posedge clk) begin
            if (en && wr && wmask[i])
                cells[addr] <= din;
        end

        always_ff @(posedge clk) begin
            if (rst)
                dout_q <= '0;
            else if (en && rd)
                dout_q <= cells[addr];
        end

        assign rdata[i*LANE_DATA_W +: LANE_DATA_W] = dout_q[LANE_DATA_W-1:0];
        assign rdata[BODY_W+i]                     = dout_q[LANE_DATA_W];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LANES       = 4,
    parameter int LANE_DATA_W = 8,
    localparam int WORD_W     = LANES * (LANE_DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cen_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwen_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oen_n,
    input  logic              sleep,
    input  logic              order_il,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              drv_en
);

    logic              awake;
    cyc_ctl_t          ctl;
    logic [LANES-1:0]  wmask;
    logic              pins_write;
    logic              live;
    logic [ADDR_W-1:0] acc_addr;

    acc_kind_e         s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic [WORD_W-1:0] s1_wdata;
    logic              out_on;

    assign awake = !sleep;

    bsram_decode #(.LANES(LANES)) u_decode (
        .cen_n      (cen_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .pstb_n     (pstb_n),
        .cstb_n     (cstb_n),
        .adv_n      (adv_n),
        .gwr_n      (gwr_n),
        .bwen_n     (bwen_n),
        .bsel_n     (bsel_n),
        .live       (live),
        .ctl        (ctl),
        .wmask      (wmask),
        .pins_write (pins_write)
    );

    bsram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (awake),
        .load     (ctl.load),
        .drop     (ctl.drop),
        .step     (ctl.step),
        .ilv      (order_il),
        .ext_addr (addr),
        .live     (live),
        .acc_addr (acc_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind  <= ACC_NONE;
            s1_addr  <= '0;
            s1_mask  <= '0;
            s1_wdata <= '0;
            out_on   <= 1'b0;
        end else if (awake) begin
            s1_kind  <= ctl.kind;
            s1_addr  <= acc_addr;
            s1_mask  <= wmask;
            s1_wdata <= wdata;
            out_on   <= (s1_kind == ACC_READ);
        end
    end

    bsram_array #(
        .ADDR_W      (ADDR_W),
        .LANES       (LANES),
        .LANE_DATA_W (LANE_DATA_W)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .en    (awake),
        .wr    (s1_kind == ACC_WRITE),
        .rd    (s1_kind == ACC_READ),
        .wmask (s1_mask),
        .addr  (s1_addr),
        .wdata (s1_wdata),
        .rdata (rdata)
    );

    assign drv_en = out_on && !oen_n && awake && !pins_write;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int LANES  = 4,
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              pstb_n,
    input logic              cstb_n,
    input logic              gwr_n,
    input logic              bwen_n,
    input logic [LANES-1:0]  bsel_n,
    input logic              oen_n,
    input logic              sleep,
    input logic [WORD_W-1:0] rdata,
    input logic              drv_en
);

    logic p_go, c_go, sel_ok, any_wr, pins_wr;
    logic desel_evt, rd_evt, wr_evt;

    assign p_go      = !pstb_n && !cen_n;
    assign c_go      = !cstb_n && !p_go;
    assign sel_ok    = !cen_n && sel_hi && !sel_lo_n;
    assign any_wr    = !gwr_n || (!bwen_n && !(&bsel_n));
    assign pins_wr   = !p_go && any_wr;
    assign desel_evt = (p_go || c_go) && !sel_ok && !sleep;
    assign rd_evt    = sel_ok && !sleep && (p_go || (c_go && !any_wr));
    assign wr_evt    = sel_ok && !sleep && c_go && any_wr;

    // R1: drivers off from the second edge after a deselect
    a_r1_desel_off: assert property (@(posedge clk) disable iff (rst)
        desel_evt ##1 !sleep |-> ##1 !drv_en);

    // R8: a registered read turns the drivers on unless gated off
    a_r8_read_drives: assert property (@(posedge clk) disable iff (rst)
        rd_evt ##1 !sleep |-> ##1 (drv_en || oen_n || sleep || pins_wr));

    // R11: a write cycle leaves the drivers off once it is performed
    a_r11_write_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_evt ##1 !sleep |-> ##1 !drv_en);

    // R12: read data holds across a sleeping edge
    a_r12_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(rdata));

    // R13: drivers are off on leaving reset
    a_r13_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> !drv_en);

endmodule

bind burst_sram bsram_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

    localparam int AW = 8;
    localparam int WW = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] t_addr;
    logic t_cen_n, t_sel_hi, t_sel_lo_n, t_pstb_n, t_cstb_n, t_adv_n;
    logic t_gwr_n, t_bwen_n, t_oen_n, t_sleep, t_ord;
    logic [3:0]    t_bsel_n;
    logic [WW-1:0] t_wdata;
    logic [WW-1:0] rdata;
    logic          drv_en;

    burst_sram u_dut (
        .clk(clk), .rst(rst), .addr(t_addr), .cen_n(t_cen_n), .sel_hi(t_sel_hi),
        .sel_lo_n(t_sel_lo_n), .pstb_n(t_pstb_n), .cstb_n(t_cstb_n), .adv_n(t_adv_n),
        .gwr_n(t_gwr_n), .bwen_n(t_bwen_n), .bsel_n(t_bsel_n), .oen_n(t_oen_n),
        .sleep(t_sleep), .order_il(t_ord), .wdata(t_wdata), .rdata(rdata), .drv_en(drv_en)
    );

    typedef struct {
        int            due;
        logic [WW-1:0] data;
        string         req;
    } exp_t;

    exp_t          q[$];
    logic [WW-1:0] ref_mem [256];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_live = 0;
    string         cur_req = "R13";

    task automatic chk(bit ok, string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw, logic [3:0] m);
        logic [WW-1:0] r;
        r = old;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                r[i*8 +: 8] = nw[i*8 +: 8];
                r[32+i]     = nw[32+i];
            end
        end
        return r;
    endfunction

    function automatic logic [WW-1:0] pat(int k);
        return {4'(k * 5 + 3), 32'(k) * 32'h9E37_79B1 + 32'h0123_4567};
    endfunction

    // Reference model per requirement; applied to the inputs of the coming edge
    task automatic tick();
        bit pg, st, sel, acc, wr;
        logic [3:0]    m;
        logic [AW-1:0] a;
        exp_t          e;
        acc = 0; wr = 0; a = '0;
        if (!t_sleep) begin
            pg  = !t_pstb_n && !t_cen_n;
            st  = pg || !t_cstb_n;
            sel = !t_cen_n && t_sel_hi && !t_sel_lo_n;
            m   = !t_gwr_n ? 4'hF : (!t_bwen_n ? ~t_bsel_n : 4'h0);
            if (st) begin
                if (!sel) m_live = 0;
                else begin
                    m_live = 1; m_base = t_addr; m_beat = 2'd0;
                    a = t_addr; acc = 1; wr = !pg && (m != 4'h0);
                end
            end else if (m_live) begin
                if (!t_adv_n) m_beat = m_beat + 2'd1;
                a = {m_base[AW-1:2], t_ord ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
                acc = 1; wr = (m != 4'h0);
            end
            if (acc && wr) ref_mem[a] = merge(ref_mem[a], t_wdata, m);
            else if (acc) begin
                e.due = cyc + 2; e.data = ref_mem[a]; e.req = cur_req;
                q.push_back(e);
            end
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
        #1;
    endtask

    task automatic rest();
        t_cen_n = 1; t_sel_hi = 1; t_sel_lo_n = 0; t_pstb_n = 1; t_cstb_n = 0;
        t_adv_n = 1; t_gwr_n = 1; t_bwen_n = 1; t_bsel_n = 4'hF; t_oen_n = 0;
        t_sleep = 0; t_addr = '0; t_wdata = '0;
    endtask

    task automatic set_cwrite(logic [AW-1:0] a, logic [WW-1:0] d, logic gw, logic bw, logic [3:0] bs);
        rest(); t_cen_n = 0; t_cstb_n = 0; t_addr = a; t_wdata = d;
        t_gwr_n = gw; t_bwen_n = bw; t_bsel_n = bs;
    endtask

    task automatic set_pread(logic [AW-1:0] a);
        rest(); t_cen_n = 0; t_pstb_n = 0; t_cstb_n = 1; t_addr = a;
    endtask

    task automatic set_cont(logic adv);
        rest(); t_cen_n = 1; t_cstb_n = 1; t_adv_n = adv;
    endtask

    task automatic drain();
        repeat (3) begin rest(); tick(); end
    endtask

    // Scoreboard monitor: compares each due read word mid-cycle
    initial begin
        forever begin
            exp_t e;
            bit   wp;
            @(negedge clk);
            #5;
            if (q.size() > 0 && q[0].due == cyc) begin
                e  = q.pop_front();
                wp = !(!t_pstb_n && !t_cen_n) && (!t_gwr_n || (!t_bwen_n && t_bsel_n != 4'hF));
                chk(rdata === e.data, e.req, "rdata", rdata, e.data);
                chk(drv_en === (!t_oen_n && !t_sleep && !wp), e.req, "drv_en",
                    WW'(drv_en), WW'(!t_oen_n && !t_sleep && !wp));
            end else if (q.size() > 0 && q[0].due < cyc) begin
                e = q.pop_front();
                chk(1'b0, e.req, "missed read", '0, e.data);
            end
        end
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", "timeout", '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [WW-1:0] held;
        rest(); t_ord = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(rdata === '0, "R13", "reset rdata", rdata, '0);
        chk(drv_en === 1'b0, "R13", "reset drv_en", WW'(drv_en), '0);
        rst = 0;

        // Fill: global-write starts (R6, R3)
        cur_req = "R6";
        for (int k = 0; k < 64; k++) begin set_cwrite(AW'(k), pat(k), 0, 1, 4'hF); tick(); end
        drain();

        cur_req = "R9";
        set_cwrite(10, pat(100), 0, 1, 4'hF); tick();
        set_pread(10); tick(); drain();

        cur_req = "R7";
        set_cwrite(11, pat(101), 1, 0, 4'b1010); tick();
        set_pread(11); tick();
        set_cwrite(15, pat(102), 1, 0, 4'b0111); tick();
        set_pread(15); tick(); drain();

        cur_req = "R6";
        set_cwrite(12, pat(103), 0, 0, 4'b1110); tick();
        set_pread(12); tick();
        set_cwrite(13, pat(104), 1, 1, 4'b0000); tick();
        set_pread(13); tick(); drain();

        cur_req = "R3";
        set_cwrite(14, pat(105), 1, 0, 4'hF); tick();
        set_pread(14); tick(); drain();

        // Linear burst with wrap from offset 1 (R5, R4, R8)
        cur_req = "R5";
        t_ord = 0;
        set_pread(5); tick();
        repeat (4) begin set_cont(0); tick(); end
        drain();

        cur_req = "R8";
        t_ord = 1;
        set_pread(6); tick();
        repeat (3) begin set_cont(0); tick(); end
        drain();
        t_ord = 0;

        cur_req = "R4";
        set_pread(20); tick();
        set_cont(1); tick();
        set_cont(1); tick();
        set_cont(0); tick();
        drain();
        set_cwrite(33, pat(106), 0, 1, 4'hF); tick();
        for (int k = 0; k < 3; k++) begin set_cont(0); t_gwr_n = 0; t_wdata = pat(107 + k); tick(); end
        set_pread(32); tick();
        repeat (3) begin set_cont(0); tick(); end
        drain();

        cur_req = "R2";
        set_pread(40); t_gwr_n = 0; t_wdata = pat(110); tick();
        set_cont(1); t_gwr_n = 0; t_wdata = pat(111); tick();
        set_pread(40); tick(); drain();

        cur_req = "R10";
        set_pread(41); tick();
        set_cont(1); t_oen_n = 1; tick();
        #4;
        chk(drv_en === 1'b0, "R10", "oe high drv_en", WW'(drv_en), '0);
        drain();

        cur_req = "R11";
        set_pread(42); tick();
        set_cont(1); t_bwen_n = 0; t_bsel_n = 4'b1101; t_wdata = pat(112); tick();
        set_pread(42); tick(); drain();

        cur_req = "R1";
        set_pread(43); tick();
        rest(); t_cen_n = 0; t_pstb_n = 0; t_cstb_n = 1; t_sel_hi = 0; tick();
        rest(); tick();
        #4;
        chk(drv_en === 1'b0, "R1", "after deselect", WW'(drv_en), '0);
        set_cont(0); tick();
        set_cont(0); tick();
        #4;
        chk(drv_en === 1'b0, "R1", "continue after deselect", WW'(drv_en), '0);
        chk(q.size() == 0, "R1", "no access after deselect", WW'(q.size()), '0);
        drain();

        cur_req = "R12";
        set_pread(44); tick(); drain();
        held = rdata;
        for (int k = 0; k < 4; k++) begin
            set_cwrite(44, pat(120 + k), 0, 1, 4'hF); t_sleep = 1; tick();
            #4;
            chk(drv_en === 1'b0, "R12", "sleep drv_en", WW'(drv_en), '0);
            chk(rdata === held, "R12", "sleep rdata", rdata, held);
        end
        rest(); tick();
        set_pread(44); tick(); drain();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule